// File: doc/BRIEF.md
# SCSI Asynchronous Data-Out Handshake Engine

This block is the target-side sequencer for an asynchronous SCSI data-out phase. It takes data words from an upstream valid/ready source and puts each word on the bus. It then pulls the active-low request line low and paces every transfer on the initiator's active-low acknowledge. When acknowledge falls, the engine releases request and fetches the following word at once. It drives request low again only after acknowledge has risen and the new word is already on the bus.

Software starts a transfer with a word count. While the transfer runs, more words can be merged into it through the append input, without stopping or restarting the engine. The append can arrive as late as the final handshake. When the count is used up and nothing further is pending, the engine pulses a done flag, releases the bus and goes idle. A programmable watchdog catches an initiator that stops responding: it aborts the transfer and raises a timeout flag.

Top module: `scsi_dout_engine`

## Requirements
- R1: Out of reset and whenever idle, `req_n_o` is 1 and `data_oe_o`, `word_ready_o`, `done_o` and `timeout_o` are 0.
- R2: After `start_i` with a non-zero `start_len_i`, the engine raises `word_ready_o` and waits for a word. It drives that word with `data_oe_o` = 1 for at least one clock before `req_n_o` goes to 0.
- R3: `req_n_o` stays 0 until the synchronised `ack_n_i` falls. It returns to 1 on the third rising clock edge after `ack_n_i` goes to 0 (two synchroniser flops, then the state register).
- R4: After a falling acknowledge, `req_n_o` stays 1 for as long as `ack_n_i` is held at 0. The next word is accepted during that time, and `req_n_o` falls again only after the synchronised `ack_n_i` has risen.
- R5: Each request presents the next upstream word in arrival order, and the total number of requests equals the scheduled word count.
- R6: `append_i` with `append_len_i` adds words to a running transfer without restarting it. This includes an append made during the last handshake. A merged transfer ends with a single one-clock `done_o` pulse.
- R7: While no upstream word is valid, the engine keeps `req_n_o` at 1 and waits. It never asserts `word_ready_o` while `req_n_o` is 0.
- R8: When the count is exhausted and the final acknowledge has risen, `done_o` pulses for exactly one clock. In that same clock `req_n_o` = 1, `data_oe_o` = 0 and `word_ready_o` = 0.
- R9: While the engine is waiting for an acknowledge edge, a wait of more than `wd_limit_i` clocks without one aborts the transfer to idle and sets `timeout_o`, which stays set until the next start. A limit of 0 disables the watchdog.
- R10: `start_i` is ignored while a transfer is running, and `append_i` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (idle only) |
| start_len_i | input | CW | Word count of the new transfer |
| append_i | input | 1 | Merge more words into the running transfer |
| append_len_i | input | CW | Number of words to merge |
| wd_limit_i | input | WW | Acknowledge timeout in clocks, 0 disables |
| word_valid_i | input | 1 | Upstream word available |
| word_data_i | input | DW | Upstream word |
| word_ready_o | output | 1 | Engine takes the upstream word this clock |
| ack_n_i | input | 1 | Initiator acknowledge, active low, asynchronous |
| req_n_o | output | 1 | Target request, active low |
| data_o | output | DW | Bus data, zero when not driven |
| data_oe_o | output | 1 | Bus data drive enable |
| done_o | output | 1 | One-clock pulse at transfer end |
| timeout_o | output | 1 | Sticky watchdog abort flag |

## Verification
The assertions assume the initiator behaves correctly. It lowers acknowledge only while request is low. It raises acknowledge only after request has gone high. It never lowers acknowledge again in the clock right after a rise. The assertions also assume that `wd_limit_i` is stable while the engine waits on acknowledge. The bench's initiator model follows these rules: it waits for request, holds acknowledge low for a set number of clocks after request is released, and changes the limit only between transfers. Appends and ignored starts are issued at clock midpoints while the engine is known to be busy or idle.

// File: rtl/sdo_pkg.sv
package sdo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_ASSERT = 2'd2
  } sdo_state_e;

endpackage

// File: rtl/sdo_ack_sync.sv
module sdo_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_i,
  output logic ack_n_sync_o,
  output logic fall_o,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  // shift chain toward the MSB; the MSB is the settled value
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], ack_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign ack_n_sync_o = sync_q[STAGES-1];
  assign fall_o       = prev_q & ~sync_q[STAGES-1];
  assign rise_o       = ~prev_q & sync_q[STAGES-1];

endmodule

// File: rtl/sdo_xfer_count.sv
module sdo_xfer_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          add_i,
  input  logic [CW-1:0] add_val_i,
  input  logic          take_i,
  output logic          empty_o
);

  logic [CW-1:0] rem_q, rem_d;
  logic          upd_en;

  assign upd_en = load_i | add_i | take_i;

  always_comb begin
    if (load_i) begin
      rem_d = load_val_i;
    end else begin
      rem_d = rem_q + (add_i ? add_val_i : '0) - {{(CW-1){1'b0}}, take_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (upd_en) begin
      rem_q <= rem_d;
    end
  end

  assign empty_o = (rem_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !add_i) |-> (rem_q != '0)); // R5

endmodule

// File: rtl/sdo_watchdog.sv
module sdo_watchdog #(
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          kick_i,
  input  logic [WW-1:0] limit_i,
  output logic          expire_o
);

  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!arm_i || kick_i) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = arm_i && !kick_i && (limit_i != '0) && (cnt_q >= limit_i);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && limit_i != '0) |-> (cnt_q <= limit_i)); // R9

endmodule

// File: rtl/scsi_dout_engine.sv
module scsi_dout_engine
  import sdo_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 16,
  parameter int WW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] start_len_i,
  input  logic          append_i,
  input  logic [CW-1:0] append_len_i,
  input  logic [WW-1:0] wd_limit_i,
  input  logic          word_valid_i,
  input  logic [DW-1:0] word_data_i,
  output logic          word_ready_o,
  input  logic          ack_n_i,
  output logic          req_n_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          done_o,
  output logic          timeout_o
);

  sdo_state_e    state_q, state_d;
  logic          loaded_q, loaded_d;
  logic          rise_q, rise_d;
  logic          oe_q, oe_d;
  logic          done_q, done_d;
  logic          tmo_q, tmo_d;
  logic [DW-1:0] data_q;

  logic ack_n_sync, ack_fall, ack_rise;
  logic cnt_load, cnt_add, cnt_empty;
  logic accept, wd_arm, wd_expire, append_live;

  sdo_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_n_i      (ack_n_i),
    .ack_n_sync_o (ack_n_sync),
    .fall_o       (ack_fall),
    .rise_o       (ack_rise)
  );

  assign append_live = append_i && (append_len_i != '0);
  assign cnt_add     = append_live && (state_q != ST_IDLE);
  assign word_ready_o = (state_q == ST_FILL) && !loaded_q && !cnt_empty;
  assign accept      = word_ready_o && word_valid_i;

  sdo_xfer_count #(.CW(CW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (start_len_i),
    .add_i      (cnt_add),
    .add_val_i  (append_len_i),
    .take_i     (accept),
    .empty_o    (cnt_empty)
  );

  // armed only while an acknowledge edge is owed by the initiator
  assign wd_arm = (state_q == ST_ASSERT) || ((state_q == ST_FILL) && !rise_q);

  sdo_watchdog #(.WW(WW)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (wd_arm),
    .kick_i   (ack_fall | ack_rise),
    .limit_i  (wd_limit_i),
    .expire_o (wd_expire)
  );

  always_comb begin
    state_d  = state_q;
    loaded_d = loaded_q;
    rise_d   = rise_q;
    oe_d     = oe_q;
    done_d   = 1'b0;
    tmo_d    = tmo_q;
    cnt_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && (start_len_i != '0)) begin
          state_d  = ST_FILL;
          rise_d   = 1'b1;
          loaded_d = 1'b0;
          tmo_d    = 1'b0;
          cnt_load = 1'b1;
        end
      end
      ST_FILL: begin
        if (wd_expire) begin
          state_d  = ST_IDLE;
          oe_d     = 1'b0;
          loaded_d = 1'b0;
          tmo_d    = 1'b1;
        end else begin
          if (ack_rise) begin
            rise_d = 1'b1;
          end
          if (accept) begin
            loaded_d = 1'b1;
            oe_d     = 1'b1;
          end
          if (rise_q && loaded_q) begin
            state_d  = ST_ASSERT;
            loaded_d = 1'b0;
            rise_d   = 1'b0;
          end else if (rise_q && !loaded_q && cnt_empty && !append_live) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
            done_d  = 1'b1;
          end
        end
      end
      ST_ASSERT: begin
        if (wd_expire) begin
          state_d = ST_IDLE;
          oe_d    = 1'b0;
          tmo_d   = 1'b1;
        end else if (ack_fall) begin
          state_d = ST_FILL;
        end
      end
      default: begin
        state_d = ST_IDLE;
        oe_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      loaded_q <= 1'b0;
      rise_q   <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      loaded_q <= loaded_d;
      rise_q   <= rise_d;
      oe_q     <= oe_d;
      done_q   <= done_d;
      tmo_q    <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= word_data_i;
    end
  end

  assign req_n_o   = (state_q != ST_ASSERT);
  assign data_oe_o = oe_q;
  assign data_o    = oe_q ? data_q : '0;
  assign done_o    = done_q;
  assign timeout_o = tmo_q;

  AST_REQ_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n_o) |-> $past(data_oe_o)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASSERT && !ack_fall && !wd_expire) |=> !req_n_o); // R3
  AST_REQ_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n_o) |-> ack_n_sync); // R4
  AST_NO_TAKE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready_o |-> req_n_o); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (req_n_o && !data_oe_o && !word_ready_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (req_n_o && !data_oe_o)); // R9

endmodule

// File: tb/scsi_dout_engine_tb.sv
module scsi_dout_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int WW = 16;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [CW-1:0] start_len_i;
  logic          append_i;
  logic [CW-1:0] append_len_i;
  logic [WW-1:0] wd_limit_i;
  logic          word_valid_i;
  logic [DW-1:0] word_data_i;
  logic          word_ready_o;
  logic          ack_n_i;
  logic          req_n_o;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          done_o;
  logic          timeout_o;

  scsi_dout_engine #(.DW(DW), .CW(CW), .WW(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_len_i(start_len_i),
    .append_i(append_i), .append_len_i(append_len_i), .wd_limit_i(wd_limit_i),
    .word_valid_i(word_valid_i), .word_data_i(word_data_i), .word_ready_o(word_ready_o),
    .ack_n_i(ack_n_i), .req_n_o(req_n_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen(input int k);
    return DW'((k * 37 + 11) & 8'hFF);
  endfunction

  // upstream source: deterministic word sequence
  int src_idx  = 0;
  int push_idx = 0;
  bit src_en   = 1'b1;
  assign word_valid_i = src_en;
  assign word_data_i  = gen(src_idx);
  always @(posedge clk) if (rst_n && word_valid_i && word_ready_o) src_idx <= src_idx + 1;

  // scoreboard
  int exp_q[$];
  int xfer_cnt = 0;
  int done_cnt = 0;
  int resp_dly = 2;
  int hold_dly = 3;
  bit init_en  = 1'b1;

  always @(negedge clk) if (rst_n && done_o) done_cnt++;

  // initiator model and monitor
  initial begin
    ack_n_i = 1'b1;
    forever begin
      @(negedge clk);
      if (init_en && rst_n && !req_n_o) begin
        int e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 request with no expected word", 1, 0);
          e = -1;
        end else begin
          e = exp_q.pop_front();
        end
        check(data_oe_o == 1'b1, "R2 bus driven at request", int'(data_oe_o), 1);
        check(int'(data_o) == e, "R5 word order", int'(data_o), e);
        xfer_cnt++;
        for (int i = 0; i < resp_dly; i++) begin
          @(negedge clk);
          check(req_n_o == 1'b0, "R3 request held before ack", int'(req_n_o), 0);
        end
        ack_n_i = 1'b0;
        @(negedge clk);
        check(req_n_o == 1'b0, "R3 request still low edge 1", int'(req_n_o), 0);
        @(negedge clk);
        check(req_n_o == 1'b0, "R3 request still low edge 2", int'(req_n_o), 0);
        @(negedge clk);
        check(req_n_o == 1'b1, "R3 request released edge 3", int'(req_n_o), 1);
        for (int i = 0; i < hold_dly; i++) begin
          @(negedge clk);
          check(req_n_o == 1'b1, "R4 no request while ack low", int'(req_n_o), 1);
        end
        ack_n_i = 1'b1;
      end
    end
  end

  task automatic do_start(input int n, input bit push);
    @(negedge clk);
    if (push) for (int i = 0; i < n; i++) exp_q.push_back(int'(gen(push_idx++)));
    start_i = 1'b1;
    start_len_i = CW'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_append(input int n, input bit push);
    @(negedge clk);
    if (push) for (int i = 0; i < n; i++) exp_q.push_back(int'(gen(push_idx++)));
    append_i = 1'b1;
    append_len_i = CW'(n);
    @(negedge clk);
    append_i = 1'b0;
  endtask

  task automatic wait_done(input int prev, input string tag);
    int n = 0;
    while (done_cnt == prev && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(done_cnt == prev + 1, tag, done_cnt, prev + 1);
  endtask

  task automatic wait_xfer(input int target);
    int n = 0;
    while (xfer_cnt < target && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int x0, d0;
    rst_n = 1'b0; start_i = 1'b0; start_len_i = '0;
    append_i = 1'b0; append_len_i = '0; wd_limit_i = WW'(200);
    repeat (5) @(negedge clk);
    check(req_n_o == 1'b1 && data_oe_o == 1'b0, "R1 reset bus quiet", int'(req_n_o), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(word_ready_o == 1'b0 && done_o == 1'b0 && timeout_o == 1'b0,
          "R1 idle flags", int'(word_ready_o), 0);

    // basic transfer of four words
    x0 = xfer_cnt; d0 = done_cnt;
    do_start(4, 1'b1);
    wait_done(d0, "R8 done after basic transfer");
    check(req_n_o == 1'b1 && data_oe_o == 1'b0 && word_ready_o == 1'b0,
          "R8 bus released at end", int'(data_oe_o), 0);
    check(xfer_cnt == x0 + 4, "R5 request count", xfer_cnt - x0, 4);
    check(exp_q.size() == 0, "R5 all words used", exp_q.size(), 0);

    // stalled source
    src_en = 1'b0;
    x0 = xfer_cnt; d0 = done_cnt;
    do_start(3, 1'b1);
    repeat (30) @(negedge clk);
    check(req_n_o == 1'b1, "R7 no request without data", int'(req_n_o), 1);
    check(xfer_cnt == x0, "R7 no transfer while stalled", xfer_cnt - x0, 0);
    check(word_ready_o == 1'b1, "R2 ready after start", int'(word_ready_o), 1);
    src_en = 1'b1;
    wait_done(d0, "R7 done after stall");
    check(xfer_cnt == x0 + 3, "R5 stalled count", xfer_cnt - x0, 3);

    // long acknowledge hold
    hold_dly = 25; resp_dly = 4;
    x0 = xfer_cnt; d0 = done_cnt;
    do_start(2, 1'b1);
    wait_done(d0, "R4 done after long hold");
    check(xfer_cnt == x0 + 2, "R4 long hold count", xfer_cnt - x0, 2);
    hold_dly = 3; resp_dly = 2;

    // merge mid-transfer, start ignored while busy
    x0 = xfer_cnt; d0 = done_cnt;
    do_start(3, 1'b1);
    wait_xfer(x0 + 1);
    do_append(4, 1'b1);
    do_start(5, 1'b0);
    wait_done(d0, "R6 done after merge");
    check(xfer_cnt == x0 + 7, "R6 merged count", xfer_cnt - x0, 7);
    check(exp_q.size() == 0, "R10 busy start ignored", exp_q.size(), 0);
    repeat (60) @(negedge clk);
    check(done_cnt == d0 + 1, "R6 single done", done_cnt - d0, 1);
    check(xfer_cnt == x0 + 7, "R10 no extra transfers", xfer_cnt - x0, 7);

    // merge during the final handshake
    x0 = xfer_cnt; d0 = done_cnt;
    do_start(1, 1'b1);
    wait_xfer(x0 + 1);
    do_append(2, 1'b1);
    wait_done(d0, "R6 done after tail merge");
    check(xfer_cnt == x0 + 3, "R6 tail merge count", xfer_cnt - x0, 3);

    // append while idle is ignored
    do_append(3, 1'b0);
    x0 = xfer_cnt; d0 = done_cnt;
    do_start(2, 1'b1);
    wait_done(d0, "R10 done after idle append");
    check(xfer_cnt == x0 + 2, "R10 idle append ignored", xfer_cnt - x0, 2);

    // watchdog abort
    init_en = 1'b0; wd_limit_i = WW'(40);
    d0 = done_cnt;
    do_start(2, 1'b0);
    repeat (100) @(negedge clk);
    check(timeout_o == 1'b1, "R9 timeout raised", int'(timeout_o), 1);
    check(req_n_o == 1'b1 && data_oe_o == 1'b0, "R9 bus released on abort", int'(req_n_o), 1);
    check(done_cnt == d0, "R9 no done on abort", done_cnt - d0, 0);
    push_idx = src_idx;
    init_en = 1'b1; wd_limit_i = WW'(200);
    x0 = xfer_cnt;
    do_start(2, 1'b1);
    check(timeout_o == 1'b0, "R9 timeout cleared by start", int'(timeout_o), 0);
    wait_done(d0, "R9 recovery transfer done");
    check(xfer_cnt == x0 + 2, "R9 recovery count", xfer_cnt - x0, 2);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule